// File: doc/BRIEF.md
# Slicer Offset and Gain Correction Controller

This block closes two slow feedback loops around one axis of a multilevel slicer. Each accepted decision word yields two feedback bits. One steers a DC offset correction word and the other a gain correction word; both words go to an external front-end amplifier ahead of the converter. Each loop is a saturating up/down integrator, so slow offset and amplitude drift is removed with a high-pass closed-loop response.

When the offset or gain error grows past half a level spacing, the loops can settle on the wrong level and hold there. A windowed monitor watches the statistics of the decisions. It counts how often the sign bit is set and how often an outermost level is decided. When either count leaves its programmed range, the controller switches to recovery mode and takes each loop's feedback from different bits of the decision word. It returns to normal mode after the statistics have been back in range for two consecutive windows.

The decision word is `LVL_BITS + 2` wide. The top `LVL_BITS` bits are the level, with the sign bit at the MSB and the second level bit directly below it. The next bit down is the error-polarity bit, and the LSB is the bit below that.

Top module: `slicer_level_ctrl`

## Requirements
- R1: After reset, both integrators hold mid-scale (`2^(ACC_W-1)`), so each correction word is `2^(CORR_W-1)`, and `recovery_o` is 0.
- R2: In normal mode, each accepted symbol moves the offset integrator by +1 when the error-polarity bit `dec_i[DEC_W-1-LVL_BITS]` is 1, and by -1 when it is 0.
- R3: In normal mode, each accepted symbol moves the gain integrator by +1 when the sign bit `dec_i[DEC_W-1]` XOR the error-polarity bit is 1, and by -1 when it is 0.
- R4: In recovery mode, the offset integrator follows the sign bit (+1 when it is 1, -1 when it is 0). The gain integrator follows the sign bit XOR the second level bit `dec_i[DEC_W-2]`.
- R5: Both integrators saturate at 0 and at `2^ACC_W-1` and never wrap.
- R6: `offset_o` and `gain_o` are the top `CORR_W` bits of their integrators.
- R7: Windows are `2^WIN_LOG` accepted symbols long. A window counts as DC-bad when its count of sign bits set differs from half the window by more than `dc_margin_i`. A difference exactly equal to the margin is in range.
- R8: A window counts as amplitude-bad when its count of outermost-level decisions (level bits all ones or all zeros) is below `outer_lo_i` or above `outer_hi_i`. Both limits are in range.
- R9: In normal mode, a window that is DC-bad or amplitude-bad sets `recovery_o` from the clock after its last symbol. The mode changes at no other point.
- R10: In recovery mode, `recovery_o` clears after two consecutive windows that are neither DC-bad nor amplitude-bad. A bad window restarts the count.
- R11: A cycle with `sym_valid_i` low changes neither integrator and does not advance the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Decision word valid this cycle |
| dec_i | input | LVL_BITS+2 | Slicer decision word: level bits, error-polarity bit, LSB |
| dc_margin_i | input | WIN_LOG | Allowed deviation of the sign-bit count from half the window |
| outer_lo_i | input | WIN_LOG+1 | Minimum outermost-level count per window |
| outer_hi_i | input | WIN_LOG+1 | Maximum outermost-level count per window |
| offset_o | output | CORR_W | DC offset correction word |
| gain_o | output | CORR_W | Gain correction word |
| recovery_o | output | 1 | High while the recovery feedback set is active |

## Verification
The bench builds the block with `ACC_W=8`, `CORR_W=4` and `WIN_LOG=4`. With 16-symbol windows and a 256-step integrator, both saturation limits and a long chain of mode changes fit in a few hundred symbols. Each correction step of 16 counts shows up as exactly one LSB of the output word. Alternating word pairs fix the window statistics exactly, so the bench can separate the normal and recovery feedback sets by their integrator deltas. Mixed windows place the sign-bit count and the outermost-level count exactly on, and one past, each programmed limit.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_RECOVER = 1'b1
  } slc_mode_e;

  localparam int unsigned NUM_LOOPS = 2;
  localparam int unsigned LOOP_OFF  = 0;
  localparam int unsigned LOOP_GAIN = 1;
endpackage

// File: rtl/slc_fb_sel.sv
module slc_fb_sel #(
  parameter int unsigned LVL_BITS = 4,
  localparam int unsigned DEC_W   = LVL_BITS + 2
) (
  input  logic [DEC_W-1:0] dec_i,
  input  logic             recovery_i,
  output logic             fb_off_o,
  output logic             fb_gain_o,
  output logic             sign_o,
  output logic             outer_o
);
  localparam int unsigned BIT_SIGN = DEC_W - 1;
  localparam int unsigned BIT_NEXT = DEC_W - 2;
  localparam int unsigned BIT_ERR  = DEC_W - 1 - LVL_BITS;

  logic [LVL_BITS-1:0] lvl;
  logic b_sign, b_next, b_err;

  assign lvl    = dec_i[DEC_W-1 -: LVL_BITS];
  assign b_sign = dec_i[BIT_SIGN];
  assign b_next = dec_i[BIT_NEXT];
  assign b_err  = dec_i[BIT_ERR];

  always_comb begin
    if (recovery_i) begin
      fb_off_o  = b_sign;
      fb_gain_o = b_sign ^ b_next;
    end else begin
      fb_off_o  = b_err;
      fb_gain_o = b_sign ^ b_err;
    end
  end

  assign sign_o  = b_sign;
  assign outer_o = (&lvl) | ~(|lvl);
endmodule

// File: rtl/slc_integ.sv
module slc_integ #(
  parameter int unsigned ACC_W  = 20,
  parameter int unsigned CORR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              up_i,
  output logic [CORR_W-1:0] corr_o
);
  localparam logic [ACC_W-1:0] ACC_MID = ACC_W'(1) << (ACC_W - 1);
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= ACC_MID;
    end else if (en_i) begin
      if (up_i && acc_q != ACC_MAX)        acc_q <= acc_q + 1'b1;
      else if (!up_i && acc_q != '0)       acc_q <= acc_q - 1'b1;
    end
  end

  assign corr_o = acc_q[ACC_W-1 -: CORR_W];

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));

  assert_unit_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (acc_q == $past(acc_q)) ||
             (acc_q == ACC_W'($past(acc_q) + 1'b1)) ||
             (acc_q == ACC_W'($past(acc_q) - 1'b1)));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && up_i && acc_q == ACC_MAX) |=> acc_q == ACC_MAX);

  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !up_i && acc_q == '0) |=> acc_q == '0);
endmodule

// File: rtl/slc_monitor.sv
module slc_monitor #(
  parameter int unsigned WIN_LOG = 10,
  localparam int unsigned CNT_W  = WIN_LOG + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               sign_i,
  input  logic               outer_i,
  input  logic [WIN_LOG-1:0] margin_i,
  input  logic [CNT_W-1:0]   outer_lo_i,
  input  logic [CNT_W-1:0]   outer_hi_i,
  output logic               win_end_o,
  output logic               bad_o
);
  localparam int unsigned      WIN  = 1 << WIN_LOG;
  localparam logic [CNT_W-1:0] HALF = CNT_W'(WIN / 2);

  logic [WIN_LOG-1:0] win_q;
  logic [CNT_W-1:0]   ones_q, outer_q, ones_nxt, outer_nxt, dev;
  logic               last, dc_bad, amp_bad;

  assign last      = &win_q;
  assign ones_nxt  = ones_q + CNT_W'(sign_i);
  assign outer_nxt = outer_q + CNT_W'(outer_i);
  assign dev       = (ones_nxt >= HALF) ? ones_nxt - HALF : HALF - ones_nxt;
  assign dc_bad    = dev > {1'b0, margin_i};
  assign amp_bad   = (outer_nxt < outer_lo_i) || (outer_nxt > outer_hi_i);
  assign win_end_o = valid_i && last;
  assign bad_o     = dc_bad || amp_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      ones_q  <= '0;
      outer_q <= '0;
    end else if (valid_i) begin
      win_q <= win_q + 1'b1;
      if (last) begin
        ones_q  <= '0;
        outer_q <= '0;
      end else begin
        ones_q  <= ones_nxt;
        outer_q <= outer_nxt;
      end
    end
  end

  assert_ones_le_seen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= {1'b0, win_q});

  assert_outer_le_seen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outer_q <= {1'b0, win_q});

  assert_win_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(win_q) && $stable(ones_q) && $stable(outer_q));
endmodule

// File: rtl/slc_mode_ctrl.sv
module slc_mode_ctrl
  import slc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_end_i,
  input  logic bad_i,
  output logic recovery_o
);
  slc_mode_e mode_q;
  logic      good_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_NORMAL;
      good_seen_q <= 1'b0;
    end else if (win_end_i) begin
      unique case (mode_q)
        MODE_NORMAL: begin
          good_seen_q <= 1'b0;
          if (bad_i) mode_q <= MODE_RECOVER;
        end
        MODE_RECOVER: begin
          if (bad_i) begin
            good_seen_q <= 1'b0;
          end else if (good_seen_q) begin
            good_seen_q <= 1'b0;
            mode_q      <= MODE_NORMAL;
          end else begin
            good_seen_q <= 1'b1;
          end
        end
        default: mode_q <= MODE_NORMAL;
      endcase
    end
  end

  assign recovery_o = (mode_q == MODE_RECOVER);

  assert_enter_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!recovery_o && win_end_i && bad_i) |=> recovery_o);

  assert_mode_only_at_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(recovery_o));

  assert_bad_keeps_recovery_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recovery_o && win_end_i && bad_i) |=> recovery_o);

  assert_exit_after_good_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(recovery_o) |-> $past(!bad_i && good_seen_q));
endmodule

// File: rtl/slicer_level_ctrl.sv
module slicer_level_ctrl
  import slc_pkg::*;
#(
  parameter int unsigned LVL_BITS = 4,
  parameter int unsigned ACC_W    = 20,
  parameter int unsigned CORR_W   = 12,
  parameter int unsigned WIN_LOG  = 10,
  localparam int unsigned DEC_W   = LVL_BITS + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sym_valid_i,
  input  logic [DEC_W-1:0]   dec_i,
  input  logic [WIN_LOG-1:0] dc_margin_i,
  input  logic [WIN_LOG:0]   outer_lo_i,
  input  logic [WIN_LOG:0]   outer_hi_i,
  output logic [CORR_W-1:0]  offset_o,
  output logic [CORR_W-1:0]  gain_o,
  output logic               recovery_o
);
  logic                 fb_off, fb_gain, sign_bit, outer_lvl;
  logic                 win_end, win_bad, recovery;
  logic [NUM_LOOPS-1:0] fb;
  logic [CORR_W-1:0]    corr [NUM_LOOPS];

  slc_fb_sel #(.LVL_BITS(LVL_BITS)) u_fb_sel (
    .dec_i      (dec_i),
    .recovery_i (recovery),
    .fb_off_o   (fb_off),
    .fb_gain_o  (fb_gain),
    .sign_o     (sign_bit),
    .outer_o    (outer_lvl)
  );

  assign fb[LOOP_OFF]  = fb_off;
  assign fb[LOOP_GAIN] = fb_gain;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    slc_integ #(.ACC_W(ACC_W), .CORR_W(CORR_W)) u_integ (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (sym_valid_i),
      .up_i   (fb[g]),
      .corr_o (corr[g])
    );
  end

  slc_monitor #(.WIN_LOG(WIN_LOG)) u_monitor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sym_valid_i),
    .sign_i     (sign_bit),
    .outer_i    (outer_lvl),
    .margin_i   (dc_margin_i),
    .outer_lo_i (outer_lo_i),
    .outer_hi_i (outer_hi_i),
    .win_end_o  (win_end),
    .bad_o      (win_bad)
  );

  slc_mode_ctrl u_mode_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_end_i  (win_end),
    .bad_i      (win_bad),
    .recovery_o (recovery)
  );

  assign offset_o   = corr[LOOP_OFF];
  assign gain_o     = corr[LOOP_GAIN];
  assign recovery_o = recovery;
endmodule

// File: tb/slicer_level_ctrl_bench.sv
module slicer_level_ctrl_bench;
  localparam int unsigned LVL_BITS = 4;
  localparam int unsigned ACC_W    = 8;
  localparam int unsigned CORR_W   = 4;
  localparam int unsigned WIN_LOG  = 4;
  localparam int unsigned WIN      = 1 << WIN_LOG;
  localparam int unsigned NVEC     = 15;

  // {word_a, word_b, windows, exp_offset, exp_gain, exp_recovery}
  // word bits: [5:2] level (sign at [5]), [1] error polarity, [0] LSB
  localparam logic [24:0] VEC [0:NVEC-1] = '{
    {6'b111110, 6'b010000, 4'd1,  4'd8,  4'd7, 1'b0}, // R2 R3 normal, gain -16
    {6'b111100, 6'b011110, 4'd1,  4'd8,  4'd8, 1'b0}, // R3 gain +16
    {6'b111110, 6'b010010, 4'd2,  4'd10, 4'd8, 1'b0}, // R2 offset +32
    {6'b000000, 6'b101100, 4'd1,  4'd9,  4'd8, 1'b0}, // R2 offset -16
    {6'b111110, 6'b000010, 4'd1,  4'd10, 4'd8, 1'b1}, // R8 R9 too many outer
    {6'b110010, 6'b100010, 4'd1,  4'd11, 4'd8, 1'b1}, // R4 recovery, DC bad
    {6'b111110, 6'b010000, 4'd1,  4'd11, 4'd8, 1'b1}, // R4 R10 first good
    {6'b111110, 6'b000010, 4'd1,  4'd11, 4'd7, 1'b1}, // R4 R10 bad restarts
    {6'b111110, 6'b010000, 4'd1,  4'd11, 4'd7, 1'b1}, // R10 one good
    {6'b111100, 6'b011110, 4'd1,  4'd11, 4'd7, 1'b0}, // R10 second good, exit
    {6'b111100, 6'b011110, 4'd1,  4'd11, 4'd8, 1'b0}, // R3 normal again
    {6'b111110, 6'b010010, 4'd8,  4'd15, 4'd8, 1'b0}, // R5 R6 top saturation
    {6'b000000, 6'b101100, 4'd1,  4'd14, 4'd8, 1'b0}, // R5 no wrap from max
    {6'b111110, 6'b010000, 4'd10, 4'd14, 4'd0, 1'b0}, // R5 bottom saturation
    {6'b111100, 6'b011110, 4'd1,  4'd14, 4'd1, 1'b0}  // R5 no wrap from zero
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sym_valid = 1'b0;
  logic [5:0]         dec = '0;
  logic [WIN_LOG-1:0] dc_margin = 4'd2;
  logic [WIN_LOG:0]   outer_lo = 5'd4;
  logic [WIN_LOG:0]   outer_hi = 5'd12;
  logic [CORR_W-1:0]  offset, gain;
  logic               recovery;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  slicer_level_ctrl #(
    .LVL_BITS(LVL_BITS), .ACC_W(ACC_W), .CORR_W(CORR_W), .WIN_LOG(WIN_LOG)
  ) u_slicer_level_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sym_valid_i (sym_valid),
    .dec_i       (dec),
    .dc_margin_i (dc_margin),
    .outer_lo_i  (outer_lo),
    .outer_hi_i  (outer_hi),
    .offset_o    (offset),
    .gain_o      (gain),
    .recovery_o  (recovery)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [5:0] w);
    @(negedge clk);
    sym_valid = 1'b1;
    dec = w;
  endtask

  task automatic idle();
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    sym_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_mix(input logic [5:0] w0, input int n0, input logic [5:0] w1, input int n1,
                          input logic [5:0] w2, input int n2, input logic [5:0] w3, input int n3);
    for (int i = 0; i < n0; i++) send(w0);
    for (int i = 0; i < n1; i++) send(w1);
    for (int i = 0; i < n2; i++) send(w2);
    for (int i = 0; i < n3; i++) send(w3);
    idle();
  endtask

  initial begin
    for (int c = 0; c < 50000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 offset", offset, 8);
    check("R1 gain", gain, 8);
    check("R1 recovery", recovery, 0);

    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < int'(VEC[v][12:9]) * WIN; i++)
        send((i % 2 == 0) ? VEC[v][24:19] : VEC[v][18:13]);
      idle();
      check($sformatf("R2-table row %0d offset", v), offset, int'(VEC[v][8:5]));
      check($sformatf("R3-table row %0d gain", v), gain, int'(VEC[v][4:1]));
      check($sformatf("R9/R10 row %0d recovery", v), recovery, int'(VEC[v][0]));
    end

    // R1 mid-run reset from a saturated, non-nominal state
    do_reset();
    @(negedge clk);
    check("R1 re-reset offset", offset, 8);
    check("R1 re-reset gain", gain, 8);

    // R11 idle symbols leave integrators and window position untouched
    for (int i = 0; i < WIN - 1; i++) send((i % 2 == 0) ? 6'b111110 : 6'b000010);
    idle();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      dec = (i % 2 == 0) ? 6'b000000 : 6'b111111;
    end
    check("R11 offset after idle", offset, 8);
    check("R11 gain after idle", gain, 7);
    check("R11 no window end while idle", recovery, 0);
    send(6'b000010);
    idle();
    check("R9 window closes on 16th valid", recovery, 1);
    check("R2 offset after window", offset, 9);
    check("R3 gain after window", gain, 8);

    // R7 deviation equal to margin stays in range, one more enters recovery
    do_reset();
    send_mix(6'b111110, 10, 6'b010000, 6, 6'b0, 0, 6'b0, 0);
    check("R7 deviation equals margin", recovery, 0);
    do_reset();
    send_mix(6'b111110, 11, 6'b010000, 5, 6'b0, 0, 6'b0, 0);
    check("R7 deviation above margin", recovery, 1);

    // R8 outer count at and past upper and lower limits
    do_reset();
    send_mix(6'b111110, 6, 6'b000000, 6, 6'b010000, 2, 6'b100010, 2);
    check("R8 outer at upper limit", recovery, 0);
    do_reset();
    send_mix(6'b111110, 7, 6'b000000, 6, 6'b010000, 2, 6'b100010, 1);
    check("R8 outer above upper limit", recovery, 1);
    do_reset();
    send_mix(6'b111110, 2, 6'b000000, 2, 6'b010000, 6, 6'b100010, 6);
    check("R8 outer at lower limit", recovery, 0);
    do_reset();
    send_mix(6'b111110, 2, 6'b000000, 1, 6'b010000, 7, 6'b100010, 6);
    check("R8 outer below lower limit", recovery, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule